// File: doc/BRIEF.md
# Fault Flag and Event Logger

This block watches a vector of fault condition lines and records what went wrong, when, and what the surrounding system looked like at that moment. Every source has two flags. A sticky history bit remembers that the source was ever active. A latched bit holds off recovery until the host clears it. The block also reports a priority fault code, and it keeps a first-fault anchor so that later secondary faults cannot hide the root cause.

A new event is a rising edge on a fault line. Each event writes one record into a ring of entries. A record holds the source code, the value of a free-running cycle counter, and a snapshot of four context inputs: supply voltage, temperature, requested target and effective target. The host reads the ring through an index/data port. An interrupt line tells the host that fresh records are waiting, and the host acknowledges it with a pulse.

Top module: `fault_event_logger`

## Requirements
- R1: A `seen` bit sets in the cycle after its fault line is high, and only reset clears it. `clr` has no effect on it.
- R2: A `latched` bit sets when its fault line is high. A `clr` pulse clears it only if that line is low in the same cycle. Otherwise the bit stays set after the line drops.
- R3: `first_code` takes the code of the first logged event after reset or after a `clr`. Later events leave it unchanged, and `clr` by itself does not change its value.
- R4: Each logged event writes the slot at `log_idx`. `log_idx` then advances by one, modulo the ring depth (16 by default).
- R5: A record stores code = source index + 1 (source 0 gives code 1), together with `vin`, `temp`, `tgt_req` and `tgt_eff` as they stand in the cycle the record is written.
- R6: The timestamp counter is zero while reset is held and increases by one every cycle after that. A record stores the counter value of its write cycle.
- R7: Fault lines that rise together are logged one per cycle in consecutive cycles, lowest source index first. Each rise produces exactly one record.
- R8: `wrap` sets on the first write that overwrites an older record (the 17th write with the default depth) and stays set until reset.
- R9: `primary_code` equals the lowest-indexed latched source plus one, or 0 when no bit is latched. It updates in the same cycle as `latched`.
- R10: `irq` goes high in the cycle after a record is written. It falls after an `irq_ack` pulse in a cycle with no write; a write in that cycle keeps it high.
- R11: The read outputs show the record in slot `rd_idx` one cycle after `rd_idx` is presented.
- R12: Following reset, all flags, codes, `log_idx`, `wrap` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_in | input | N_SRC | Fault condition level per source |
| vin | input | VAL_W | Supply voltage sample for snapshots |
| temp | input | VAL_W | Temperature sample for snapshots |
| tgt_req | input | VAL_W | Requested target for snapshots |
| tgt_eff | input | VAL_W | Effective target for snapshots |
| clr | input | 1 | Host clear pulse for latched bits; re-arms first-fault capture |
| irq_ack | input | 1 | Host acknowledge for the interrupt |
| rd_idx | input | log2(DEPTH) | Ring slot to read |
| rd_code | output | CODE_W | Code of the record read |
| rd_seq | output | SEQ_W | Timestamp of the record read |
| rd_vin | output | VAL_W | Supply snapshot of the record read |
| rd_temp | output | VAL_W | Temperature snapshot of the record read |
| rd_req | output | VAL_W | Requested-target snapshot of the record read |
| rd_eff | output | VAL_W | Effective-target snapshot of the record read |
| seen | output | N_SRC | Sticky history flags |
| latched | output | N_SRC | Latched flags |
| primary_code | output | CODE_W | Priority code of latched faults, 0 if none |
| first_code | output | CODE_W | First-fault anchor |
| log_idx | output | log2(DEPTH) | Next ring slot to be written |
| wrap | output | 1 | Set once an old record has been overwritten |
| irq | output | 1 | New record interrupt |

## Verification
The bench drives several lines rising in the same cycle. A design that logged only one of them, or logged them out of order, would leave the wrong codes and timestamps in consecutive slots. It issues `clr` while a source is still active and while others have gone quiet. A design that dropped a live latch, kept a dead one, wiped the history bits or reset the first-fault anchor would show it on the flag ports. Random traffic pushes the ring well past one lap, so a design that set `wrap` too early or too late, or shifted a snapshot by a cycle, fails the full ring readback. It also sends an acknowledge in the same cycle as a write, and a design that let the acknowledge win would drop `irq`.

// File: rtl/fel_pkg.sv
package fel_pkg;
  // Index of the lowest set bit, or -1 when none is set.
  function automatic int lowest_set(input logic [63:0] v);
    int r;
    r = -1;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/fel_arbiter.sv
module fel_arbiter #(
  parameter int N_SRC  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  fault_in,
  output logic              ev_vld,
  output logic [CODE_W-1:0] ev_code
);
  logic [N_SRC-1:0] prev_q, pend_q, cand, grant;

  always_comb begin
    cand    = pend_q | (fault_in & ~prev_q);
    grant   = '0;
    ev_code = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        ev_code  = CODE_W'(i + 1);
      end
    end
  end

  assign ev_vld = |cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= fault_in;
      pend_q <= cand & ~grant;
    end
  end

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_pend_drains_R7: assert property (@(posedge clk) disable iff (rst)
    ev_vld |=> ((pend_q & $past(grant)) == '0));
endmodule

// File: rtl/fel_flags.sv
module fel_flags #(
  parameter int N_SRC  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  fault_in,
  input  logic              clr,
  input  logic              ev_vld,
  input  logic [CODE_W-1:0] ev_code,
  output logic [N_SRC-1:0]  seen,
  output logic [N_SRC-1:0]  latched,
  output logic [CODE_W-1:0] primary_code,
  output logic [CODE_W-1:0] first_code
);
  import fel_pkg::*;

  logic [N_SRC-1:0] lat_d;
  logic             armed_q;

  assign lat_d = (latched & ~{N_SRC{clr}}) | fault_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen         <= '0;
      latched      <= '0;
      primary_code <= '0;
      first_code   <= '0;
      armed_q      <= 1'b1;
    end else begin
      seen         <= seen | fault_in;
      latched      <= lat_d;
      primary_code <= CODE_W'(lowest_set(64'(lat_d)) + 1);
      if (ev_vld && armed_q) first_code <= ev_code;
      armed_q      <= clr | (armed_q & ~ev_vld);
    end
  end

  assert_seen_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    ((seen & $past(seen)) == $past(seen)));
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((latched & $past(latched)) == $past(latched)));
  assert_first_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> $stable(first_code));
  assert_primary_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ((latched == '0) == (primary_code == '0)));
endmodule

// File: rtl/fel_ring.sv
module fel_ring #(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 4,
  parameter int SEQ_W  = 16,
  parameter int VAL_W  = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CODE_W-1:0] code,
  input  logic [VAL_W-1:0]  vin,
  input  logic [VAL_W-1:0]  temp,
  input  logic [VAL_W-1:0]  tgt_req,
  input  logic [VAL_W-1:0]  tgt_eff,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [VAL_W-1:0]  rd_vin,
  output logic [VAL_W-1:0]  rd_temp,
  output logic [VAL_W-1:0]  rd_req,
  output logic [VAL_W-1:0]  rd_eff,
  output logic [IDX_W-1:0]  log_idx,
  output logic              wrap
);
  localparam int ENT_W = CODE_W + SEQ_W + 4 * VAL_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic [SEQ_W-1:0] ts_q;
  logic             full_q;

  always_ff @(posedge clk) begin
    if (we) mem[log_idx] <= {code, ts_q, vin, temp, tgt_req, tgt_eff};
    rd_q <= mem[rd_idx];
  end

  assign {rd_code, rd_seq, rd_vin, rd_temp, rd_req, rd_eff} = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q    <= '0;
      log_idx <= '0;
      full_q  <= 1'b0;
      wrap    <= 1'b0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (we) begin
        log_idx <= (log_idx == LAST) ? '0 : log_idx + 1'b1;
        full_q  <= full_q | (log_idx == LAST);
        wrap    <= wrap | full_q;
      end
    end
  end

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (rst)
    we |=> (log_idx == (($past(log_idx) == LAST) ? '0 : $past(log_idx) + 1'b1)));
  assert_idx_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(log_idx));
  assert_ts_step_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ts_q == $past(ts_q) + 1'b1));
  assert_wrap_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(wrap) |-> wrap);
endmodule

// File: rtl/fault_event_logger.sv
module fault_event_logger #(
  parameter int N_SRC = 8,
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int VAL_W = 12,
  localparam int CODE_W = $clog2(N_SRC + 1),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  fault_in,
  input  logic [VAL_W-1:0]  vin,
  input  logic [VAL_W-1:0]  temp,
  input  logic [VAL_W-1:0]  tgt_req,
  input  logic [VAL_W-1:0]  tgt_eff,
  input  logic              clr,
  input  logic              irq_ack,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [VAL_W-1:0]  rd_vin,
  output logic [VAL_W-1:0]  rd_temp,
  output logic [VAL_W-1:0]  rd_req,
  output logic [VAL_W-1:0]  rd_eff,
  output logic [N_SRC-1:0]  seen,
  output logic [N_SRC-1:0]  latched,
  output logic [CODE_W-1:0] primary_code,
  output logic [CODE_W-1:0] first_code,
  output logic [IDX_W-1:0]  log_idx,
  output logic              wrap,
  output logic              irq
);
  logic              ev_vld;
  logic [CODE_W-1:0] ev_code;

  fel_arbiter #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_arb (
    .clk(clk), .rst(rst), .fault_in(fault_in),
    .ev_vld(ev_vld), .ev_code(ev_code)
  );

  fel_flags #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_flags (
    .clk(clk), .rst(rst), .fault_in(fault_in), .clr(clr),
    .ev_vld(ev_vld), .ev_code(ev_code),
    .seen(seen), .latched(latched),
    .primary_code(primary_code), .first_code(first_code)
  );

  fel_ring #(.DEPTH(DEPTH), .CODE_W(CODE_W), .SEQ_W(SEQ_W), .VAL_W(VAL_W)) u_ring (
    .clk(clk), .rst(rst), .we(ev_vld), .code(ev_code),
    .vin(vin), .temp(temp), .tgt_req(tgt_req), .tgt_eff(tgt_eff),
    .rd_idx(rd_idx), .rd_code(rd_code), .rd_seq(rd_seq),
    .rd_vin(rd_vin), .rd_temp(rd_temp), .rd_req(rd_req), .rd_eff(rd_eff),
    .log_idx(log_idx), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (ev_vld)  irq <= 1'b1;
    else if (irq_ack) irq <= 1'b0;
  end

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ev_vld));
  assert_irq_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    ev_vld |=> irq);
endmodule

// File: tb/fault_event_logger_tb.sv
module fault_event_logger_tb;
  localparam int NS = 8, VW = 12, SW = 16, DEP = 16, CW = 4, IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NS-1:0] fault_in = '0;
  logic [VW-1:0] vin = '0, temp = '0, tgt_req = '0, tgt_eff = '0;
  logic          clr = 1'b0, irq_ack = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [CW-1:0] rd_code, primary_code, first_code;
  logic [SW-1:0] rd_seq;
  logic [VW-1:0] rd_vin, rd_temp, rd_req, rd_eff;
  logic [NS-1:0] seen, latched;
  logic [IW-1:0] log_idx;
  logic          wrap, irq;

  fault_event_logger #(.N_SRC(NS), .DEPTH(DEP), .SEQ_W(SW), .VAL_W(VW)) u_dut (
    .clk(clk), .rst(rst), .fault_in(fault_in), .vin(vin), .temp(temp),
    .tgt_req(tgt_req), .tgt_eff(tgt_eff), .clr(clr), .irq_ack(irq_ack),
    .rd_idx(rd_idx), .rd_code(rd_code), .rd_seq(rd_seq), .rd_vin(rd_vin),
    .rd_temp(rd_temp), .rd_req(rd_req), .rd_eff(rd_eff), .seen(seen),
    .latched(latched), .primary_code(primary_code), .first_code(first_code),
    .log_idx(log_idx), .wrap(wrap), .irq(irq)
  );

  // Cycle counter following R6: zero in reset, +1 per cycle after.
  logic [SW-1:0] tb_cyc;
  always_ff @(posedge clk) begin
    if (rst) tb_cyc <= '0;
    else     tb_cyc <= tb_cyc + 1'b1;
  end

  int checks = 0, errors = 0;

  // Reference model state
  logic [NS-1:0] m_seen = '0, m_lat = '0, m_prev = '0, m_pend = '0;
  logic [CW-1:0] m_prim = '0, m_first = '0;
  logic          m_armed = 1'b1, m_full = 1'b0, m_wrap = 1'b0, m_irq = 1'b0;
  int            m_idx = 0;
  logic [CW-1:0] e_code [DEP];
  logic [SW-1:0] e_seq  [DEP];
  logic [VW-1:0] e_vin [DEP], e_temp [DEP], e_req [DEP], e_eff [DEP];

  function automatic logic [CW-1:0] low_code(input logic [NS-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = NS - 1; i >= 0; i--) if (v[i]) c = CW'(i + 1);
    return c;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs();
    chk("R1", "seen", 64'(seen), 64'(m_seen));
    chk("R2", "latched", 64'(latched), 64'(m_lat));
    chk("R9", "primary_code", 64'(primary_code), 64'(m_prim));
    chk("R3", "first_code", 64'(first_code), 64'(m_first));
    chk("R4", "log_idx", 64'(log_idx), 64'(m_idx));
    chk("R8", "wrap", 64'(wrap), 64'(m_wrap));
    chk("R10", "irq", 64'(irq), 64'(m_irq));
  endtask

  task automatic model_update();
    logic [NS-1:0] cand;
    logic [CW-1:0] code;
    cand = m_pend | (fault_in & ~m_prev);
    code = low_code(cand);
    if (cand != '0) begin
      e_code[m_idx] = code;
      e_seq[m_idx]  = tb_cyc;
      e_vin[m_idx]  = vin;
      e_temp[m_idx] = temp;
      e_req[m_idx]  = tgt_req;
      e_eff[m_idx]  = tgt_eff;
      if (m_full) m_wrap = 1'b1;
      if (m_idx == DEP - 1) m_full = 1'b1;
      m_idx = (m_idx + 1) % DEP;
      m_irq = 1'b1;
      if (m_armed) m_first = code;
      cand[code - 1] = 1'b0;
    end else if (irq_ack) begin
      m_irq = 1'b0;
    end
    m_armed = clr | (m_armed & (code == '0));
    m_pend  = cand;
    m_prev  = fault_in;
    m_seen  = m_seen | fault_in;
    m_lat   = (m_lat & ~{NS{clr}}) | fault_in;
    m_prim  = low_code(m_lat);
  endtask

  task automatic cycle(input logic [NS-1:0] f, input logic c, input logic a);
    fault_in = f;
    clr      = c;
    irq_ack  = a;
    vin      = VW'($urandom);
    temp     = VW'($urandom);
    tgt_req  = VW'($urandom);
    tgt_eff  = VW'($urandom);
    model_update();
    @(negedge clk);
    check_outs();
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] f;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: state right after reset
    check_outs();
    chk("R12", "primary after reset", 64'(primary_code), 64'd0);

    // Single fault on source 2 -> code 3
    cycle(8'h04, 1'b0, 1'b0);
    chk("R5", "first code of source 2", 64'(first_code), 64'd3);
    cycle(8'h00, 1'b0, 1'b0);   // R2: latch holds after the line drops

    // R7: sources 0, 5 and 7 rise together
    cycle(8'hA1, 1'b0, 1'b0);
    chk("R7", "one record per cycle", 64'(log_idx), 64'd2);
    cycle(8'hA1, 1'b0, 1'b0);
    cycle(8'hA1, 1'b0, 1'b0);
    chk("R7", "burst fully logged", 64'(log_idx), 64'd4);

    // R2/R3: clear with only source 7 still active
    cycle(8'h80, 1'b1, 1'b0);
    chk("R2", "live latch survives clear", 64'(latched), 64'h80);
    chk("R3", "clear keeps anchor", 64'(first_code), 64'd3);
    chk("R1", "clear leaves history", 64'(seen), 64'hA5);
    cycle(8'h90, 1'b0, 1'b0);   // source 4 -> first becomes 5
    chk("R3", "anchor re-armed", 64'(first_code), 64'd5);
    cycle(8'h92, 1'b0, 1'b0);   // source 1 rises -> anchor frozen
    chk("R3", "later fault ignored", 64'(first_code), 64'd5);

    // R10: ack in an idle cycle clears, ack with a write keeps irq high
    cycle(8'h92, 1'b0, 1'b1);
    chk("R10", "ack clears irq", 64'(irq), 64'd0);
    cycle(8'h93, 1'b0, 1'b1);
    chk("R10", "write beats ack", 64'(irq), 64'd1);

    // Constrained random traffic, wraps the ring several times
    f = 8'h93;
    for (int n = 0; n < 400; n++) begin
      f = f ^ NS'($urandom & $urandom & $urandom);
      cycle(f, ($urandom % 16) == 0, ($urandom % 4) == 0);
    end
    chk("R8", "wrap after many events", 64'(wrap), 64'd1);

    // Drain, then read back every slot (R5, R6, R11)
    for (int n = 0; n < 12; n++) cycle(f, 1'b0, 1'b0);
    for (int i = 0; i < DEP; i++) begin
      rd_idx = IW'(i);
      cycle(f, 1'b0, 1'b0);
      chk("R11", "rd_code", 64'(rd_code), 64'(e_code[i]));
      chk("R6", "rd_seq", 64'(rd_seq), 64'(e_seq[i]));
      chk("R5", "rd_vin", 64'(rd_vin), 64'(e_vin[i]));
      chk("R5", "rd_temp", 64'(rd_temp), 64'(e_temp[i]));
      chk("R5", "rd_req", 64'(rd_req), 64'(e_req[i]));
      chk("R5", "rd_eff", 64'(rd_eff), 64'(e_eff[i]));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule